// File: doc/BRIEF.md
# Page Write Staging Buffer with Timed Commit

This block sits between a two-wire serial protocol engine and a byte-wide storage array. During a write transfer the engine hands it one data byte at a time, and the block keeps each byte in a small staging buffer that covers one page of `COLS` bytes. The first byte of a transfer fixes the page row and the starting column. Each later byte goes to the next column, and the column wraps within the same page. A per-column valid mask records which columns have been filled.

When the engine reports a stop condition after at least one byte, the block starts a self-timed commit. It raises `busy` for exactly `COMMIT_CYCLES` clocks. During that window it writes only the loaded columns into the array, one per clock, in ascending column order. The engine uses `busy` to refuse acknowledgement while the commit runs, and the block ignores every strobe until the commit has finished.

A repeated start condition in place of a stop throws the staged bytes away. A high write-protect level at the stop also throws them away. In both cases no commit starts and `busy` never rises.

Top module: `page_write_stager`

## Requirements
- R1: After reset `busy` and `memWe` are 0 and the staging buffer is empty.
- R2: The first byte of a transfer goes to column `colIn`, and the row on `rowIn` is latched with that byte. Each later byte goes to the previous column plus one, and later `rowIn` values are ignored. The array address is `{row, column}`, with the column in the low log2(COLS) bits.
- R3: The column wraps from COLS-1 to 0 in the same row. A column that is loaded again keeps only its most recent byte, and that byte is written once.
- R4: A stop with at least one byte staged and `wpIn` low sets `busy` in the cycle after the stop strobe. From that cycle on, `memWe` is high for one clock per loaded column, in ascending column order with no gaps. Columns that were not loaded are never written.
- R5: `busy` stays high for exactly `COMMIT_CYCLES` cycles and then falls. The buffer is empty afterwards.
- R6: A stop with no byte staged starts no commit.
- R7: A `startStb` pulse outside a commit discards all staged bytes. No array write follows, and a later stop starts nothing.
- R8: If `wpIn` is high at the stop, no array write occurs, `busy` never rises, and the staged bytes are discarded.
- R9: While `busy` is high, `byteStb`, `stopStb` and `startStb` have no effect. Bytes sent then are never written, and the commit length does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byteStb | input | 1 | One received data byte is present |
| byteData | input | DATA_W | Data byte |
| colIn | input | log2(COLS) | Starting column within the page, used by the first byte only |
| rowIn | input | ROW_W | Page row, latched with the first byte |
| stopStb | input | 1 | Stop condition ended the transfer |
| startStb | input | 1 | Repeated start ended the transfer |
| wpIn | input | 1 | Write-protect level, sampled at the stop |
| busy | output | 1 | Commit in progress; the engine must not acknowledge |
| memWe | output | 1 | Array write enable |
| memAddr | output | ROW_W+log2(COLS) | Array write address |
| memWdata | output | DATA_W | Array write data |

## Verification
The bench builds the block with a 16-byte page, a 6-bit row and an 8-bit data path. It shortens the commit window to 24 clocks, which leaves 8 cycles of slack after a full 16-byte page. That short window lets many complete commits, and the strobes injected into the middle of them, fit into a short run. With 16 columns and 6 row bits the bench can start a transfer near the end of a page, send more than a page of bytes, and see the wrap and overwrite in the address and data that reach the array.

// File: rtl/page_stager_pkg.sv
package page_stager_pkg;

  // Strobes from the control module to the datapath module
  typedef struct packed {
    logic loadByte;    // stage the current byte
    logic clearAll;    // drop every staged byte
    logic retireByte;  // write the lowest staged column and clear it
  } stagerCtl_t;

  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_COMMIT  = 1'b1
  } stagerState_t;

endpackage

// File: rtl/page_stager_ctrl.sv
module page_stager_ctrl
  import page_stager_pkg::*;
#(
  parameter int COMMIT_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byteStb,
  input  logic       stopStb,
  input  logic       startStb,
  input  logic       wpIn,
  input  logic       anyLoaded,
  output stagerCtl_t ctl,
  output logic       busy
);

  localparam int TMR_W = $clog2(COMMIT_CYCLES + 1);

  stagerState_t state;
  logic [TMR_W-1:0] timer;
  logic commitGo;

  // Only a stop with staged bytes and protection off opens a commit
  assign commitGo = (state == ST_COLLECT) && stopStb && anyLoaded && !wpIn;

  always_comb begin
    ctl = '0;
    if (state == ST_COLLECT) begin
      if (stopStb) begin
        ctl.clearAll = !commitGo;
      end else if (startStb) begin
        ctl.clearAll = 1'b1;
      end else if (byteStb) begin
        ctl.loadByte = 1'b1;
      end
    end else begin
      ctl.retireByte = anyLoaded;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_COLLECT;
      timer <= '0;
    end else begin
      case (state)
        ST_COLLECT: begin
          if (commitGo) begin
            state <= ST_COMMIT;
            timer <= TMR_W'(COMMIT_CYCLES - 1);
          end
        end
        default: begin
          if (timer == '0) begin
            state <= ST_COLLECT;
          end else begin
            timer <= timer - 1'b1;
          end
        end
      endcase
    end
  end

  assign busy = (state == ST_COMMIT);

endmodule

// File: rtl/page_stager_dp.sv
module page_stager_dp
  import page_stager_pkg::*;
#(
  parameter int COLS   = 16,
  parameter int ROW_W  = 6,
  parameter int DATA_W = 8,
  localparam int COL_W = $clog2(COLS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  stagerCtl_t             ctl,
  input  logic [DATA_W-1:0]      byteData,
  input  logic [COL_W-1:0]       colIn,
  input  logic [ROW_W-1:0]       rowIn,
  output logic                   anyLoaded,
  output logic                   memWe,
  output logic [ROW_W+COL_W-1:0] memAddr,
  output logic [DATA_W-1:0]      memWdata
);

  logic [COLS-1:0]   validMask;
  logic [COL_W-1:0]  colPtr;
  logic [COL_W-1:0]  slot;
  logic [COL_W-1:0]  lowIdx;
  logic [ROW_W-1:0]  rowReg;
  logic              firstByte;
  logic [DATA_W-1:0] cellOut [COLS];

  assign firstByte = (validMask == '0);
  assign slot      = firstByte ? colIn : colPtr;

  // One byte register per column
  for (genvar g = 0; g < COLS; g++) begin : gCol
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (ctl.loadByte && (slot == COL_W'(g))) begin
        q <= byteData;
      end
    end
    assign cellOut[g] = q;
  end

  // Lowest loaded column is committed first
  always_comb begin
    lowIdx = '0;
    for (int i = COLS - 1; i >= 0; i--) begin
      if (validMask[i]) lowIdx = i[COL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validMask <= '0;
      colPtr    <= '0;
      rowReg    <= '0;
    end else if (ctl.clearAll) begin
      validMask <= '0;
    end else if (ctl.loadByte) begin
      validMask[slot] <= 1'b1;
      colPtr          <= slot + 1'b1;
      if (firstByte) rowReg <= rowIn;
    end else if (ctl.retireByte) begin
      validMask[lowIdx] <= 1'b0;
    end
  end

  assign anyLoaded = |validMask;
  assign memWe     = ctl.retireByte;
  assign memAddr   = {rowReg, lowIdx};
  assign memWdata  = cellOut[lowIdx];

endmodule

// File: rtl/page_write_stager.sv
module page_write_stager
  import page_stager_pkg::*;
#(
  parameter int COLS          = 16,
  parameter int ROW_W         = 6,
  parameter int DATA_W        = 8,
  parameter int COMMIT_CYCLES = 500000,
  localparam int COL_W        = $clog2(COLS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   byteStb,
  input  logic [DATA_W-1:0]      byteData,
  input  logic [COL_W-1:0]       colIn,
  input  logic [ROW_W-1:0]       rowIn,
  input  logic                   stopStb,
  input  logic                   startStb,
  input  logic                   wpIn,
  output logic                   busy,
  output logic                   memWe,
  output logic [ROW_W+COL_W-1:0] memAddr,
  output logic [DATA_W-1:0]      memWdata
);

  stagerCtl_t ctl;
  logic       anyLoaded;

  page_stager_ctrl #(
    .COMMIT_CYCLES(COMMIT_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .byteStb  (byteStb),
    .stopStb  (stopStb),
    .startStb (startStb),
    .wpIn     (wpIn),
    .anyLoaded(anyLoaded),
    .ctl      (ctl),
    .busy     (busy)
  );

  page_stager_dp #(
    .COLS  (COLS),
    .ROW_W (ROW_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .byteData (byteData),
    .colIn    (colIn),
    .rowIn    (rowIn),
    .anyLoaded(anyLoaded),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

endmodule

// File: rtl/page_stager_chk.sv
module page_stager_chk #(
  parameter int COLS          = 16,
  parameter int ROW_W         = 6,
  parameter int COMMIT_CYCLES = 500000,
  localparam int COL_W        = $clog2(COLS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   stopStb,
  input logic                   wpIn,
  input logic                   busy,
  input logic                   memWe,
  input logic [ROW_W+COL_W-1:0] memAddr
);

  int unsigned busyCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busyCnt <= 0;
    else if (busy) busyCnt <= busyCnt + 1;
    else busyCnt <= 0;
  end

  // R4: array writes happen only inside a commit
  a_r4_write_in_commit: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> busy);

  // R4: columns of one commit are written in strictly ascending order
  a_r4_ascending_cols: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe && $past(memWe)) |-> (memAddr[COL_W-1:0] > $past(memAddr[COL_W-1:0])));

  // R2: the row stays fixed within one commit
  a_r2_row_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe && $past(memWe)) |-> (memAddr[ROW_W+COL_W-1:COL_W] == $past(memAddr[ROW_W+COL_W-1:COL_W])));

  // R4, R8: a commit opens only after an unprotected stop
  a_r8_rise_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(stopStb) && !$past(wpIn)));

  // R8: a protected stop never raises busy
  a_r8_wp_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (stopStb && wpIn && !busy) |=> !busy);

  // R5: busy lasts exactly the commit window
  a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busyCnt == COMMIT_CYCLES));

  a_r5_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busyCnt < COMMIT_CYCLES));

endmodule

bind page_write_stager page_stager_chk #(
  .COLS         (COLS),
  .ROW_W        (ROW_W),
  .COMMIT_CYCLES(COMMIT_CYCLES)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .stopStb(stopStb),
  .wpIn   (wpIn),
  .busy   (busy),
  .memWe  (memWe),
  .memAddr(memAddr)
);

// File: tb/page_write_stager_tb.sv
`timescale 1ns/1ps
module page_write_stager_tb;

  localparam int COLS   = 16;
  localparam int ROW_W  = 6;
  localparam int DATA_W = 8;
  localparam int CYC    = 24;
  localparam int COL_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byteStb = 1'b0;
  logic [DATA_W-1:0] byteData = '0;
  logic [COL_W-1:0] colIn = '0;
  logic [ROW_W-1:0] rowIn = '0;
  logic stopStb = 1'b0;
  logic startStb = 1'b0;
  logic wpIn = 1'b0;
  logic busy, memWe;
  logic [ROW_W+COL_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;

  always #4 clk = ~clk;

  page_write_stager #(
    .COLS(COLS), .ROW_W(ROW_W), .DATA_W(DATA_W), .COMMIT_CYCLES(CYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .byteStb(byteStb), .byteData(byteData),
    .colIn(colIn), .rowIn(rowIn), .stopStb(stopStb), .startStb(startStb),
    .wpIn(wpIn), .busy(busy), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata)
  );

  int tests = 0;
  int fails = 0;
  int wrSeen = 0;
  int busySeen = 0;
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int mBuf [COLS];
  bit mValid [COLS];
  int mCol = 0;
  int mRow = 0;
  int mBusyCnt = 0;
  int qAddr [$];
  int qData [$];

  function automatic bit anyValid();
    for (int i = 0; i < COLS; i++) if (mValid[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < COLS; i++) mValid[i] = 0;
      mBusyCnt = 0;
      qAddr.delete();
      qData.delete();
    end else if (mBusyCnt > 0) begin
      if (qAddr.size() > 0) begin
        void'(qAddr.pop_front());
        void'(qData.pop_front());
      end
      mBusyCnt--;
    end else if (stopStb) begin
      if (anyValid() && !wpIn) begin
        for (int i = 0; i < COLS; i++) begin
          if (mValid[i]) begin
            qAddr.push_back(mRow * COLS + i);
            qData.push_back(mBuf[i]);
          end
        end
        mBusyCnt = CYC;
      end
      for (int i = 0; i < COLS; i++) mValid[i] = 0;
    end else if (startStb) begin
      for (int i = 0; i < COLS; i++) mValid[i] = 0;
    end else if (byteStb) begin
      int c;
      if (!anyValid()) begin
        c = int'(colIn);
        mRow = int'(rowIn);
      end else begin
        c = mCol;
      end
      mBuf[c] = int'(byteData);
      mValid[c] = 1;
      mCol = (c + 1) % COLS;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit expWe;
      expWe = (mBusyCnt > 0) && (qAddr.size() > 0);
      chk("R5 busy vs model", int'(busy), int'(mBusyCnt > 0));
      chk("R4 memWe vs model", int'(memWe), int'(expWe));
      if (expWe && memWe) begin
        chk("R2 memAddr vs model", int'(memAddr), qAddr[0]);
        chk("R3 memWdata vs model", int'(memWdata), qData[0]);
      end
      if (memWe) wrSeen++;
      if (busy) busySeen++;
    end
  end

  task automatic sendByte(int col, int row, int data);
    byteStb = 1'b1;
    colIn = COL_W'(col);
    rowIn = ROW_W'(row);
    byteData = DATA_W'(data);
    @(negedge clk);
    byteStb = 1'b0;
  endtask

  task automatic pulseStop();
    stopStb = 1'b1;
    @(negedge clk);
    stopStb = 1'b0;
  endtask

  task automatic pulseStart();
    startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
  endtask

  task automatic settle();
    repeat (CYC + 3) @(negedge clk);
  endtask

  task automatic finish();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    int w0, b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 memWe after reset", int'(memWe), 0);

    // R1, R6: stop with nothing staged
    w0 = wrSeen; b0 = busySeen;
    pulseStop();
    settle();
    chk("R6 no writes on empty stop", wrSeen - w0, 0);
    chk("R6 no busy on empty stop", busySeen - b0, 0);

    // R4, R5: single byte
    w0 = wrSeen; b0 = busySeen;
    sendByte(5, 3, 8'hA5);
    pulseStop();
    chk("R4 busy in cycle after stop", int'(busy), 1);
    chk("R4 first write address", int'(memAddr), 3 * 16 + 5);
    settle();
    chk("R4 single byte write count", wrSeen - w0, 1);
    chk("R5 busy cycle count", busySeen - b0, CYC);

    // R2, R3, R4: partial page across the wrap, row changes ignored
    w0 = wrSeen;
    sendByte(14, 10, 8'h11);
    sendByte(0, 33, 8'h22);
    sendByte(7, 44, 8'h33);
    pulseStop();
    chk("R2 row latched from first byte", int'(memAddr), 10 * 16 + 0);
    chk("R3 wrapped byte data", int'(memWdata), 8'h33);
    settle();
    chk("R4 partial write count", wrSeen - w0, 3);

    // R3: overflow of a page, 20 bytes from column 2
    w0 = wrSeen;
    for (int i = 0; i < 20; i++) sendByte(2, 7, 8'h40 + i);
    pulseStop();
    chk("R3 column 2 keeps latest byte", int'(memAddr), 7 * 16 + 0);
    settle();
    chk("R3 overflow writes each column once", wrSeen - w0, 16);

    // R7: repeated start discards
    w0 = wrSeen; b0 = busySeen;
    for (int i = 0; i < 4; i++) sendByte(1, 2, 8'h90 + i);
    pulseStart();
    pulseStop();
    settle();
    chk("R7 no writes after restart", wrSeen - w0, 0);
    chk("R7 no busy after restart", busySeen - b0, 0);

    // R8: write protect at stop
    w0 = wrSeen; b0 = busySeen;
    sendByte(4, 5, 8'hC1);
    sendByte(4, 5, 8'hC2);
    wpIn = 1'b1;
    pulseStop();
    chk("R8 busy low after protected stop", int'(busy), 0);
    wpIn = 1'b0;
    settle();
    chk("R8 no writes under protect", wrSeen - w0, 0);
    chk("R8 no busy under protect", busySeen - b0, 0);
    w0 = wrSeen;
    sendByte(9, 1, 8'hD7);
    pulseStop();
    settle();
    chk("R8 protected bytes were discarded", wrSeen - w0, 1);

    // R9: strobes during a commit are ignored
    w0 = wrSeen; b0 = busySeen;
    sendByte(12, 20, 8'hE1);
    sendByte(0, 20, 8'hE2);
    pulseStop();
    sendByte(3, 8, 8'hF0);
    pulseStop();
    sendByte(4, 8, 8'hF1);
    pulseStart();
    sendByte(5, 8, 8'hF2);
    settle();
    chk("R9 commit length unchanged", busySeen - b0, CYC);
    chk("R9 only staged bytes written", wrSeen - w0, 2);
    w0 = wrSeen; b0 = busySeen;
    pulseStop();
    settle();
    chk("R9 bytes sent while busy never staged", wrSeen - w0, 0);
    chk("R9 no second commit", busySeen - b0, 0);
    chk("R5 idle after commit", int'(busy), 0);

    finish();
  end

endmodule